// File: doc/BRIEF.md
# Clock Level Transition Sequencer

This block moves a processor clock tree between five performance levels: level 0 runs at 1000 MHz, level 1 at 800, level 2 at 400, level 3 at 200 and level 4 at 100 MHz. A request names a target level. The sequencer compares the target with the level it has recorded as current and then works through a fixed order of steps. It asks two supply controllers for new voltages, writes divider, mux, lock-time and PLL words to a register file, and polls busy and lock status vectors between steps. At fixed points it also sends a rescale trigger to the memory refresh logic.

Two decisions are made separately for each move. The first is whether the PLL must be reprogrammed. When it must, the CPU domain is parked on the alternate PLL, and the media domain is parked as well, so the switch is glitch-free. The second is whether the memory bus speed must change. Voltage steps come before the clock work when the move goes up in frequency, and after it when the move goes down.

A sleep or shutdown request takes the machine to level 1 and then locks it. While it is locked, every request is refused with a reject pulse until a wake input clears the lock. Every status wait has a programmable timeout. When a wait times out, the machine raises a fault and keeps its old recorded level.

Top module: `clk_level_seq`

## Requirements
- R1: After reset the block is idle, `cur_level` is 1, `locked` is 0, and the pulse outputs (`done`, `fault`, `rej`), `wr_en`, `vreq_valid` and `rfsh_valid` are all 0.
- R2: When a request names the current level, `done` is high in the cycle that follows the accepting edge. No register write, voltage request or refresh trigger is issued.
- R3: Voltage order depends on the direction of the move. For a move to a lower level number (higher frequency), the core rail (`vreq_rail`=0) is requested first and then the internal rail (`vreq_rail`=1), each waiting for `vack`, before any register write. For a move to a higher level number, the internal rail and then the core rail are requested after the last write and after the last refresh trigger. `vreq_level` carries the target.
- R4: A PLL swap happens only when the old or the new level is 0. Before the divider update it writes, in this order:
  - media dividers, addr 1, value 0x33, then waits until `div_stat0[17:16]` is 0;
  - media mux, addr 4, value 0x3, then waits until `mux_stat1[7]` and `mux_stat1[3]` are 0;
  - CPU mux, addr 3, value 0x1, then waits until `mux_stat0[18]` is 0.
- R5: The main divider word goes to addr 0 in a single write, with field i (0..7) at bits [4i+3:4i]. The block then waits until `div_stat0[7:0]` is 0. The words per level are:

  | Level | Word |
  |---|---|
  | 0 | 0x14131440 |
  | 1 | 0x14131330 |
  | 2 | 0x14131131 |
  | 3 | 0x14131133 |
  | 4 | 0x09070077 |
- R6: After the divider update, addr 5 is written with 0x3 for targets 3 and 4 and with 0x1 for the other targets.
- R7: During a swap, addr 6 is written with 0x2CF. Then addr 7 is written with the PLL word {enable bit 31, M at [25:16], P at [13:8], S at [2:0]}: 0x807D0301 for target 0 and 0x80640301 otherwise. The block then waits until `pll_stat[29]` is 1.
- R8: The swap is restored in this order:
  - addr 4 is written with 0 (wait as in R4);
  - addr 1 is written with 0x00 (wait as in R4);
  - addr 3 is written with 0 (wait as in R4).
- R9: A memory-bus change happens only when the old or the new level is 4. After the clock work it writes the shared-memory divider to addr 2 (7 for target 4, 3 otherwise) and waits until `div_stat1[15]` is 0.
- R10: Refresh triggers (`rfsh_ch`, `rfsh_mhz`) are issued at fixed points in the move:
  - bus change, before the clock work: ch1 at 83 MHz if a swap is also done, otherwise ch1 at 100 MHz; then ch0 at 83 MHz.
  - swap without a bus change: ch1 at 133 MHz before the CPU mux write, and ch1 at 200 MHz after the restore.
  - bus change, at the end: ch0 at 166 MHz and ch1 at 200 MHz, or for target 4 ch0 at 83 MHz and ch1 at 100 MHz.
- R11: A request is refused with a one-cycle `rej` pulse in the cycle after the edge if the block is locked or if the level is above 4. A refused request changes nothing and starts no activity.
- R12: `sleep_req` moves the block to level 1. `locked` becomes 1 one cycle after the `done` pulse. `wake_req` clears `locked`.
- R13: If a status wait exceeds `tmo_limit` cycles, the block pulses `fault`, keeps `cur_level` unchanged and returns to idle. The pulses `done`, `fault` and `rej` never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Level change request |
| req_level | input | 3 | Requested level |
| sleep_req | input | 1 | Sleep/shutdown request: go to level 1 and lock |
| wake_req | input | 1 | Clears the lock |
| tmo_limit | input | TW | Timeout for each status wait, in cycles |
| vack | input | 1 | Supply controller acknowledge |
| div_stat0 | input | 32 | Divider busy status (main and media) |
| div_stat1 | input | 32 | Divider busy status (shared memory) |
| mux_stat0 | input | 32 | CPU mux busy status |
| mux_stat1 | input | 32 | Media mux busy status |
| pll_stat | input | 32 | PLL status, lock at bit 29 |
| busy | output | 1 | Move in progress |
| done | output | 1 | Move complete pulse |
| fault | output | 1 | Timeout pulse |
| rej | output | 1 | Request refused pulse |
| locked | output | 1 | Lock state |
| cur_level | output | 3 | Recorded current level |
| vreq_valid | output | 1 | Voltage request pulse |
| vreq_rail | output | 1 | 0 core, 1 internal |
| vreq_level | output | 3 | Level for the new voltage |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register address |
| wr_data | output | 32 | Register write data |
| rfsh_valid | output | 1 | Refresh rescale trigger |
| rfsh_ch | output | 1 | Memory channel |
| rfsh_mhz | output | 8 | New memory clock in MHz |

## Verification
A request is accepted on an edge. For a same-level or refused request, the result (`done` or `rej`) appears in the very next cycle, so the bench samples it at the following falling edge. `locked` and `cur_level` change one cycle after `done`, and they are checked one falling edge later. Writes, voltage requests and refresh triggers come at times that depend on the status responders. For that reason their order and content are matched against a queue as each strobe appears, and not at fixed cycles; an empty queue left at `done` or `fault` is checked as well. A stuck busy vector with a short `tmo_limit` drives the fault path.

// File: rtl/clk_level_seq.sv
module clk_level_seq #(
  parameter int TW = 16,
  parameter logic [2:0] RST_LVL = 3'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_level,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [TW-1:0] tmo_limit,
  input  logic          vack,
  input  logic [31:0]   div_stat0,
  input  logic [31:0]   div_stat1,
  input  logic [31:0]   mux_stat0,
  input  logic [31:0]   mux_stat1,
  input  logic [31:0]   pll_stat,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          rej,
  output logic          locked,
  output logic [2:0]    cur_level,
  output logic          vreq_valid,
  output logic          vreq_rail,
  output logic [2:0]    vreq_level,
  output logic          wr_en,
  output logic [2:0]    wr_addr,
  output logic [31:0]   wr_data,
  output logic          rfsh_valid,
  output logic          rfsh_ch,
  output logic [7:0]    rfsh_mhz
);
  localparam logic [2:0] A_DIV0 = 3'd0, A_DIV2 = 3'd1, A_DIV6 = 3'd2, A_SRC0 = 3'd3,
                         A_SRC2 = 3'd4, A_MCS = 3'd5, A_LOCK = 3'd6, A_PCON = 3'd7;
  localparam logic [2:0] W_VACK = 3'd0, W_MDIV = 3'd1, W_MMUX = 3'd2, W_CMUX = 3'd3,
                         W_MAIN = 3'd4, W_LOCK = 3'd5, W_SDIV = 3'd6;

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_VU_CORE, S_VU_INT, S_RF_PRE1, S_RF_PRE0, S_P_DIV2, S_P_SRC2,
    S_P_RF, S_P_SRC0, S_DIV0, S_MCS, S_LOCK, S_PCON, S_R_SRC2, S_R_DIV2, S_R_SRC0,
    S_R_RF, S_B_DIV6, S_B_RF0, S_B_RF1, S_VD_INT, S_VD_CORE, S_WAIT, S_DONE, S_FAULT
  } st_t;

  st_t st, ret;
  logic [2:0] tgt, wsel;
  logic [TW-1:0] cnt;
  logic slp;

  function automatic logic [43:0] dtab(input logic [2:0] l);
    case (l)
      3'd0:    dtab = 44'h00314131440;
      3'd1:    dtab = 44'h00314131330;
      3'd2:    dtab = 44'h00314131131;
      3'd3:    dtab = 44'h00314131133;
      default: dtab = 44'h00709070077;
    endcase
  endfunction

  wire [43:0] dv  = dtab(tgt);
  wire pll = (tgt == 3'd0) || (cur_level == 3'd0);
  wire bus = (tgt == 3'd4) || (cur_level == 3'd4);
  wire up  = tgt < cur_level;
  wire dn  = tgt > cur_level;
  wire [2:0] eff = sleep_req ? 3'd1 : req_level;
  wire t4  = tgt == 3'd4;

  st_t n_dn, n_pll, n_pre;
  assign n_dn  = dn ? S_VD_INT : S_DONE;
  assign n_pll = pll ? S_P_DIV2 : S_DIV0;
  assign n_pre = bus ? S_RF_PRE1 : n_pll;

  logic wok;
  always_comb begin
    case (wsel)
      W_VACK:  wok = vack;
      W_MDIV:  wok = ~|div_stat0[17:16];
      W_MMUX:  wok = ~(mux_stat1[7] | mux_stat1[3]);
      W_CMUX:  wok = ~mux_stat0[18];
      W_MAIN:  wok = ~|div_stat0[7:0];
      W_LOCK:  wok = pll_stat[29];
      default: wok = ~div_stat1[15];
    endcase
  end

  assign busy  = st != S_IDLE;
  assign done  = st == S_DONE;
  assign fault = st == S_FAULT;
  assign vreq_valid = st inside {S_VU_CORE, S_VU_INT, S_VD_INT, S_VD_CORE};
  assign vreq_rail  = st inside {S_VU_INT, S_VD_INT};
  assign vreq_level = tgt;
  assign rfsh_valid = st inside {S_RF_PRE1, S_RF_PRE0, S_P_RF, S_R_RF, S_B_RF0, S_B_RF1};
  assign rfsh_ch    = !(st inside {S_RF_PRE0, S_B_RF0});

  always_comb begin
    case (st)
      S_RF_PRE1: rfsh_mhz = pll ? 8'd83 : 8'd100;
      S_P_RF:    rfsh_mhz = 8'd133;
      S_R_RF:    rfsh_mhz = 8'd200;
      S_B_RF0:   rfsh_mhz = t4 ? 8'd83 : 8'd166;
      S_B_RF1:   rfsh_mhz = t4 ? 8'd100 : 8'd200;
      default:   rfsh_mhz = 8'd83;
    endcase
  end

  always_comb begin
    wr_en = 1'b1;
    wr_addr = A_DIV0;
    wr_data = '0;
    case (st)
      S_P_DIV2: begin wr_addr = A_DIV2; wr_data = 32'h33; end
      S_P_SRC2: begin wr_addr = A_SRC2; wr_data = 32'h3; end
      S_P_SRC0: begin wr_addr = A_SRC0; wr_data = 32'h1; end
      S_DIV0:   begin wr_addr = A_DIV0; wr_data = dv[31:0]; end
      S_MCS:    begin wr_addr = A_MCS;  wr_data = (tgt >= 3'd3) ? 32'h3 : 32'h1; end
      S_LOCK:   begin wr_addr = A_LOCK; wr_data = 32'h2CF; end
      S_PCON:   begin wr_addr = A_PCON;
                      wr_data = {1'b1, 5'd0, (tgt == 3'd0) ? 10'd125 : 10'd100, 2'd0, 6'd3, 5'd0, 3'd1}; end
      S_R_SRC2: wr_addr = A_SRC2;
      S_R_DIV2: begin wr_addr = A_DIV2; wr_data = {24'd0, dv[43:40], dv[39:36]}; end
      S_R_SRC0: wr_addr = A_SRC0;
      S_B_DIV6: begin wr_addr = A_DIV6; wr_data = {28'd0, dv[35:32]}; end
      default:  wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; tgt <= RST_LVL; cur_level <= RST_LVL;
      wsel <= W_VACK; cnt <= '0; slp <= 1'b0; locked <= 1'b0; rej <= 1'b0;
    end else begin
      rej <= 1'b0;
      if (wake_req) locked <= 1'b0;
      cnt <= '0;
      case (st)
        S_IDLE: if (req_valid || sleep_req) begin
          if (locked || (!sleep_req && req_level > 3'd4)) rej <= 1'b1;
          else begin
            tgt <= eff; slp <= sleep_req;
            st <= (eff == cur_level) ? S_DONE : S_START;
          end
        end
        S_START:   st <= up ? S_VU_CORE : n_pre;
        S_VU_CORE: begin st <= S_WAIT; wsel <= W_VACK; ret <= S_VU_INT; end
        S_VU_INT:  begin st <= S_WAIT; wsel <= W_VACK; ret <= n_pre; end
        S_RF_PRE1: st <= S_RF_PRE0;
        S_RF_PRE0: st <= n_pll;
        S_P_DIV2:  begin st <= S_WAIT; wsel <= W_MDIV; ret <= S_P_SRC2; end
        S_P_SRC2:  begin st <= S_WAIT; wsel <= W_MMUX; ret <= bus ? S_P_SRC0 : S_P_RF; end
        S_P_RF:    st <= S_P_SRC0;
        S_P_SRC0:  begin st <= S_WAIT; wsel <= W_CMUX; ret <= S_DIV0; end
        S_DIV0:    begin st <= S_WAIT; wsel <= W_MAIN; ret <= S_MCS; end
        S_MCS:     st <= pll ? S_LOCK : (bus ? S_B_DIV6 : n_dn);
        S_LOCK:    st <= S_PCON;
        S_PCON:    begin st <= S_WAIT; wsel <= W_LOCK; ret <= S_R_SRC2; end
        S_R_SRC2:  begin st <= S_WAIT; wsel <= W_MMUX; ret <= S_R_DIV2; end
        S_R_DIV2:  begin st <= S_WAIT; wsel <= W_MDIV; ret <= S_R_SRC0; end
        S_R_SRC0:  begin st <= S_WAIT; wsel <= W_CMUX; ret <= bus ? S_B_DIV6 : S_R_RF; end
        S_R_RF:    st <= n_dn;
        S_B_DIV6:  begin st <= S_WAIT; wsel <= W_SDIV; ret <= S_B_RF0; end
        S_B_RF0:   st <= S_B_RF1;
        S_B_RF1:   st <= n_dn;
        S_VD_INT:  begin st <= S_WAIT; wsel <= W_VACK; ret <= S_VD_CORE; end
        S_VD_CORE: begin st <= S_WAIT; wsel <= W_VACK; ret <= S_DONE; end
        S_WAIT:
          if (wok) st <= ret;
          else if (cnt >= tmo_limit) st <= S_FAULT;
          else cnt <= cnt + 1'b1;
        S_DONE: begin
          cur_level <= tgt;
          if (slp) locked <= 1'b1;
          slp <= 1'b0;
          st <= S_IDLE;
        end
        default: begin slp <= 1'b0; tgt <= cur_level; st <= S_IDLE; end
      endcase
    end
  end
endmodule

module clk_level_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_level,
  input logic       sleep_req,
  input logic       busy,
  input logic       done,
  input logic       fault,
  input logic       rej,
  input logic       locked,
  input logic [2:0] cur_level,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [31:0] wr_data
);
  AST_SAME_LEVEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sleep_req && !busy && !locked && req_level == cur_level) |=> done); // R2
  AST_REJ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && locked) |=> rej); // R11
  AST_MCS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd5) |-> (wr_data == 32'h3 || wr_data == 32'h1)); // R6
  AST_PLL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |-> (wr_data[31] && wr_data[13:8] == 6'd3 && wr_data[2:0] == 3'd1)); // R7
  AST_FAULT_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(cur_level)); // R13
  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, rej})); // R13
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
endmodule

bind clk_level_seq clk_level_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
  .sleep_req(sleep_req), .busy(busy), .done(done), .fault(fault), .rej(rej),
  .locked(locked), .cur_level(cur_level), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/clk_level_seq_tb.sv
`timescale 1ns/1ps
module clk_level_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, sleep_req = 0, wake_req = 0;
  logic [2:0] req_level = 0;
  logic [15:0] tmo_limit = 16'd30;
  logic vack;
  logic [31:0] div_stat0, div_stat1, mux_stat0, mux_stat1, pll_stat;
  logic busy, done, fault, rej, locked, vreq_valid, vreq_rail, wr_en, rfsh_valid, rfsh_ch;
  logic [2:0] cur_level, vreq_level, wr_addr;
  logic [31:0] wr_data;
  logic [7:0] rfsh_mhz;

  always #2.5 clk = ~clk;

  clk_level_seq dut_i (.*);

  int errors = 0, checks = 0;
  logic stuck = 0;
  int c_m = 0, c_d = 0, c_x0 = 0, c_x1 = 0, c_6 = 0, c_l = 0, c_v = 0;

  always @(posedge clk) begin
    c_m <= (c_m > 0) ? c_m - 1 : 0;  c_d <= (c_d > 0) ? c_d - 1 : 0;
    c_x0 <= (c_x0 > 0) ? c_x0 - 1 : 0; c_x1 <= (c_x1 > 0) ? c_x1 - 1 : 0;
    c_6 <= (c_6 > 0) ? c_6 - 1 : 0;  c_l <= (c_l > 0) ? c_l - 1 : 0;
    c_v <= (c_v > 0) ? c_v - 1 : 0;
    if (vreq_valid) c_v <= 3;
    if (wr_en) case (wr_addr)
      3'd1: c_m <= 3;  3'd0: c_d <= 4;  3'd4: c_x1 <= 2;
      3'd3: c_x0 <= 2; 3'd2: c_6 <= 3;  3'd7: c_l <= 5;
      default: ;
    endcase
  end
  assign vack = (c_v == 1);
  assign div_stat0 = {14'd0, {2{c_m != 0}}, 8'd0, {8{(c_d != 0) || stuck}}};
  assign div_stat1 = {16'd0, c_6 != 0, 15'd0};
  assign mux_stat0 = {13'd0, c_x0 != 0, 18'd0};
  assign mux_stat1 = {24'd0, c_x1 != 0, 3'd0, c_x1 != 0, 3'd0};
  assign pll_stat  = {2'd0, c_l == 0, 29'd0};

  logic [36:0] q_item[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic push(input logic [1:0] k, input logic [2:0] a, input logic [31:0] d, input string tag);
    q_item.push_back({k, a, d}); q_tag.push_back(tag);
  endtask
  task automatic pw(input logic [2:0] a, input logic [31:0] d, input string tag); push(2'd1, a, d, tag); endtask
  task automatic pv(input bit rail, input int l, input string tag); push(2'd2, {2'd0, rail}, l, tag); endtask
  task automatic pr(input bit ch, input int mhz, input string tag); push(2'd3, {2'd0, ch}, mhz, tag); endtask

  function automatic logic [31:0] div_word(input int l);
    case (l)
      0: return 32'h14131440; 1: return 32'h14131330; 2: return 32'h14131131;
      3: return 32'h14131133; default: return 32'h09070077;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && (wr_en || vreq_valid || rfsh_valid)) begin
    logic [36:0] got;
    got = wr_en ? {2'd1, wr_addr, wr_data} : vreq_valid ? {2'd2, 2'd0, vreq_rail, 29'd0, vreq_level}
                : {2'd3, 2'd0, rfsh_ch, 24'd0, rfsh_mhz};
    if (q_item.size() == 0) chk(0, "R2 unexpected activity", got, 0);
    else begin
      logic [36:0] e; string t;
      e = q_item.pop_front(); t = q_tag.pop_front();
      chk(got == e, t, got, e);
    end
  end

  task automatic expect_move(input int o, input int t);
    bit pll, bus;
    pll = (o == 0) || (t == 0); bus = (o == 4) || (t == 4);
    if (t < o) begin pv(0, t, "R3 core up"); pv(1, t, "R3 int up"); end
    if (bus) begin pr(1, pll ? 83 : 100, "R10 pre ch1"); pr(0, 83, "R10 pre ch0"); end
    if (pll) begin
      pw(1, 32'h33, "R4 media div"); pw(4, 32'h3, "R4 media mux");
      if (!bus) pr(1, 133, "R10 ch1 133");
      pw(3, 32'h1, "R4 cpu mux");
    end
    pw(0, div_word(t), "R5 div word");
    pw(5, (t >= 3) ? 32'h3 : 32'h1, "R6 mcs");
    if (pll) begin
      pw(6, 32'h2CF, "R7 lock time");
      pw(7, (t == 0) ? 32'h807D0301 : 32'h80640301, "R7 pll word");
      pw(4, 32'h0, "R8 media mux back"); pw(1, 32'h0, "R8 media div");
      pw(3, 32'h0, "R8 cpu mux back");
      if (!bus) pr(1, 200, "R10 ch1 200");
    end
    if (bus) begin
      pw(2, (t == 4) ? 32'd7 : 32'd3, "R9 shared div");
      pr(0, (t == 4) ? 83 : 166, "R10 end ch0"); pr(1, (t == 4) ? 100 : 200, "R10 end ch1");
    end
    if (t > o) begin pv(1, t, "R3 int down"); pv(0, t, "R3 core down"); end
  endtask

  task automatic wait_end(output bit d, output bit f);
    d = 0; f = 0;
    for (int i = 0; i < 3000 && !d && !f; i++) begin @(negedge clk); d = done; f = fault; end
  endtask

  task automatic move(input int t, input bit slp);
    bit d, f; int o;
    o = cur_level;
    if (o != t) expect_move(o, t);
    @(negedge clk);
    if (slp) sleep_req = 1; else begin req_valid = 1; req_level = t[2:0]; end
    @(negedge clk); req_valid = 0; sleep_req = 0;
    if (o == t) begin d = done; f = fault; chk(done, "R2 immediate done", done, 1); end
    else wait_end(d, f);
    chk(d && !f, "R3 move completes", {f, d}, 1);
    chk(q_item.size() == 0, "R4 all steps issued", q_item.size(), 0);
    @(negedge clk);
    chk(cur_level == t, "R5 level recorded", cur_level, t);
    chk(locked == slp, "R12 lock after move", locked, slp);
  endtask

  task automatic try_rej(input int l, input string tag);
    int o; o = cur_level;
    @(negedge clk); req_valid = 1; req_level = l[2:0];
    @(negedge clk); req_valid = 0;
    chk(rej, tag, rej, 1);
    chk(!busy, "R11 no activity after reject", busy, 0);
    @(negedge clk);
    chk(cur_level == o, "R11 level kept", cur_level, o);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    bit d, f;
    repeat (3) @(negedge clk);
    chk(cur_level == 1 && !locked && !busy && !done && !fault && !rej && !wr_en && !vreq_valid && !rfsh_valid,
        "R1 reset state", {cur_level, locked, busy}, 64'h4);
    rst_n = 1;
    @(negedge clk);
    move(2, 0);
    move(0, 0);
    move(4, 0);
    move(3, 0);
    move(3, 0);
    move(0, 0);
    move(1, 0);
    try_rej(5, "R11 bad level rejected");
    // R13 timeout on main divider wait
    stuck = 1; tmo_limit = 16'd10;
    pw(0, div_word(2), "R13 div word before fault");
    @(negedge clk); req_valid = 1; req_level = 3'd2;
    @(negedge clk); req_valid = 0;
    wait_end(d, f);
    chk(f && !d, "R13 fault raised", {f, d}, 2);
    @(negedge clk);
    chk(cur_level == 1, "R13 level unchanged", cur_level, 1);
    stuck = 0; tmo_limit = 16'd30;
    repeat (6) @(negedge clk);
    move(1, 1);
    try_rej(0, "R11 locked rejects");
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
    chk(!locked, "R12 wake clears lock", locked, 0);
    move(3, 0);
    move(1, 1);
    try_rej(2, "R12 sleep locks");
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
    move(4, 0);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule